// File: doc/BRIEF.md
# Priority-Field Interrupt Enable Controller

This block collects one request line per interrupt source and presents the single winning request as a vector code and a priority level. Software controls each source through 4-bit priority fields packed into priority registers. Two sources are also gated by individual bits of a mask word. The mask word has one address that sets bits and another address that clears them. Some priority fields govern a whole group of sources: one field covers a pair of timer sources and another covers four serial-port sources.

A source is enabled only when every control assigned to it is non-zero. For each source the block counts how many of its controls are non-zero and compares that count with the number of controls the source has. Among enabled sources that are requesting, the one with the highest level wins. The result is registered and follows any change of request or register by one cycle. Register access uses a plain byte-addressed read/write strobe bus, and read data is registered.

Top module: `prio_field_intc`

## Requirements
- R1: After a synchronous reset every register reads zero, every source is disabled and `irq_valid` is 0.
- R2: Register A at byte address 0x00 and register B at 0x04 are 16 bits wide. A write stores `bus_wdata[15:0]` and a read returns the value zero-extended. In A, bits 15:12 control source 0 and bits 11:8 control source 1. In B, bits 15:12 control source 8, bits 11:8 control source 9 and bits 7:4 control source 10. B bits 3:0 are reserved.
- R3: The wide register at 0x08 is 32 bits and holds eight 4-bit fields. Bits 31:28 control source 11. The other seven fields are stored and read back but affect no source.
- R4: Writing the mask set address 0x0C ORs the write data into the mask word. Writing the mask clear address 0x10 clears the bits that are 1 in the write data. Both addresses read back the mask word. Mask bit 31 gates source 10, bit 30 gates source 11, and the other bits affect no source.
- R5: Group fields: A bits 7:4 control sources 2 and 3, and A bits 3:0 control sources 4, 5, 6 and 7. Each member takes that field's value as its level.
- R6: A source is enabled only when all of its controls are non-zero. Source 10 needs both B[7:4] and mask bit 31. Source 11 needs both wide[31:28] and mask bit 30.
- R7: The vector code of source i is the 12-bit value 0x400 + 0x20*i.
- R8: Among sources that are requesting and enabled, the winner is the one with the highest level. On a tie the lowest index wins. A level of 0 never wins.
- R9: `irq_valid`, `irq_level` and `irq_vector` are registered. They reflect the request and register state with one cycle of latency. `bus_rdata` is valid in the cycle after `bus_rd`.
- R10: A read from any other address returns zero. A write to any other address changes no register and no output.
- R11: Writing a register with the value it already holds leaves the output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_req | input | 12 | One request line per source, bit i for source i |
| irq_valid | output | 1 | A winning request is present |
| irq_level | output | 4 | Level of the winner |
| irq_vector | output | 12 | Vector code of the winner |

## Verification
The bench targets the following corner cases and the failure each one would expose:
- Group fan-out: a design that decodes a group field for one member only drops requests from the other members.
- The doubly gated sources are driven with only one of their two controls set. A design that treats any single non-zero control as enough reports a winner here.
- The set and clear mask addresses are exercised with overlapping bit patterns. A design that stores the raw write value instead of merging it loses bits the test set earlier.
- Equal levels test the tie-break; a wrong tie order shows up as the higher-indexed vector.
- Reserved fields, unmapped addresses and same-value rewrites must leave the output untouched.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
  localparam int NUM_SRC    = 12;
  localparam int FIELD_W    = 4;
  localparam int NUM_FIELDS = 16;
  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 32;
  localparam int HALF_W     = 16;
  localparam int VEC_W      = 12;
  localparam int VEC_BASE   = 'h400;
  localparam int VEC_STEP   = 'h20;

  localparam logic [ADDR_W-1:0] ADR_PRIO_A = 5'h00;
  localparam logic [ADDR_W-1:0] ADR_PRIO_B = 5'h04;
  localparam logic [ADDR_W-1:0] ADR_PRIO_W = 5'h08;
  localparam logic [ADDR_W-1:0] ADR_MSET   = 5'h0C;
  localparam logic [ADDR_W-1:0] ADR_MCLR   = 5'h10;

  // Flat field index: 0..3 register A (MSB nibble first), 4..7 register B,
  // 8..15 wide register.
  function automatic int src_field(int s);
    case (s)
      0: return 0;
      1: return 1;
      2, 3: return 2;
      4, 5, 6, 7: return 3;
      8: return 4;
      9: return 5;
      10: return 6;
      default: return 8;
    endcase
  endfunction

  // Mask bit gating a source, -1 when the source has no mask control.
  function automatic int src_mask_bit(int s);
    case (s)
      10: return 31;
      11: return 30;
      default: return -1;
    endcase
  endfunction

  function automatic logic [VEC_W-1:0] src_vector(int s);
    return VEC_W'(VEC_BASE + s * VEC_STEP);
  endfunction
endpackage

// File: rtl/prio_intc_regs.sv
module prio_intc_regs
  import prio_intc_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic                          bus_wr,
  input  logic                          bus_rd,
  input  logic [DATA_W-1:0]             bus_wdata,
  output logic [DATA_W-1:0]             bus_rdata,
  output logic [NUM_FIELDS*FIELD_W-1:0] fields,
  output logic [DATA_W-1:0]             mask
);
  localparam int A_FIELDS = HALF_W / FIELD_W;
  localparam int W_FIELDS = DATA_W / FIELD_W;

  logic [HALF_W-1:0] prio_a_q, prio_b_q;
  logic [DATA_W-1:0] prio_w_q, mask_q;
  logic              hit;

  always_comb begin
    hit = (bus_addr == ADR_PRIO_A) || (bus_addr == ADR_PRIO_B) ||
          (bus_addr == ADR_PRIO_W) || (bus_addr == ADR_MSET) ||
          (bus_addr == ADR_MCLR);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prio_a_q <= '0;
      prio_b_q <= '0;
      prio_w_q <= '0;
      mask_q   <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        ADR_PRIO_A: prio_a_q <= bus_wdata[HALF_W-1:0];
        ADR_PRIO_B: prio_b_q <= bus_wdata[HALF_W-1:0];
        ADR_PRIO_W: prio_w_q <= bus_wdata;
        ADR_MSET:   mask_q   <= mask_q | bus_wdata;
        ADR_MCLR:   mask_q   <= mask_q & ~bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        ADR_PRIO_A: bus_rdata <= {{(DATA_W-HALF_W){1'b0}}, prio_a_q};
        ADR_PRIO_B: bus_rdata <= {{(DATA_W-HALF_W){1'b0}}, prio_b_q};
        ADR_PRIO_W: bus_rdata <= prio_w_q;
        ADR_MSET, ADR_MCLR: bus_rdata <= mask_q;
        default:    bus_rdata <= '0;
      endcase
    end
  end

  always_comb begin
    for (int k = 0; k < A_FIELDS; k++) begin
      fields[k*FIELD_W +: FIELD_W]              = prio_a_q[(A_FIELDS-1-k)*FIELD_W +: FIELD_W];
      fields[(A_FIELDS+k)*FIELD_W +: FIELD_W]   = prio_b_q[(A_FIELDS-1-k)*FIELD_W +: FIELD_W];
    end
    for (int k = 0; k < W_FIELDS; k++) begin
      fields[(2*A_FIELDS+k)*FIELD_W +: FIELD_W] = prio_w_q[(W_FIELDS-1-k)*FIELD_W +: FIELD_W];
    end
  end

  assign mask = mask_q;

  assert_mask_set_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADR_MSET) |=> mask_q == ($past(mask_q) | $past(bus_wdata)));
  assert_mask_clr_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADR_MCLR) |=> mask_q == ($past(mask_q) & ~$past(bus_wdata)));
  assert_unmapped_wr_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !hit) |=> ($stable(prio_a_q) && $stable(prio_b_q) &&
                          $stable(prio_w_q) && $stable(mask_q)));
  assert_unmapped_rd_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !hit) |=> bus_rdata == '0);
endmodule

// File: rtl/prio_intc_enable.sv
module prio_intc_enable
  import prio_intc_pkg::*;
(
  input  logic [NUM_FIELDS*FIELD_W-1:0] fields,
  input  logic [DATA_W-1:0]             mask,
  output logic [NUM_SRC-1:0]            src_en,
  output logic [NUM_SRC*FIELD_W-1:0]    src_lvl
);
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    localparam int FIDX = src_field(s);
    localparam int MBIT = src_mask_bit(s);
    logic [FIELD_W-1:0] fld;
    logic [1:0]         on_cnt, need_cnt;

    assign fld = fields[FIDX*FIELD_W +: FIELD_W];
    assign src_lvl[s*FIELD_W +: FIELD_W] = fld;

    if (MBIT >= 0) begin : g_masked
      assign on_cnt   = 2'(fld != '0) + 2'(mask[MBIT]);
      assign need_cnt = 2'd2;
    end else begin : g_plain
      assign on_cnt   = 2'(fld != '0);
      assign need_cnt = 2'd1;
    end

    assign src_en[s] = (on_cnt == need_cnt);
  end
endmodule

// File: rtl/prio_intc_arbiter.sv
module prio_intc_arbiter
  import prio_intc_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_SRC-1:0]         irq_req,
  input  logic [NUM_SRC-1:0]         src_en,
  input  logic [NUM_SRC*FIELD_W-1:0] src_lvl,
  output logic                       irq_valid,
  output logic [FIELD_W-1:0]         irq_level,
  output logic [VEC_W-1:0]           irq_vector
);
  logic               win_v;
  logic [FIELD_W-1:0] win_l;
  logic [VEC_W-1:0]   win_vec;

  always_comb begin
    win_v   = 1'b0;
    win_l   = '0;
    win_vec = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (irq_req[s] && src_en[s] && src_lvl[s*FIELD_W +: FIELD_W] > win_l) begin
        win_v   = 1'b1;
        win_l   = src_lvl[s*FIELD_W +: FIELD_W];
        win_vec = src_vector(s);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_valid  <= 1'b0;
      irq_level  <= '0;
      irq_vector <= '0;
    end else begin
      irq_valid  <= win_v;
      irq_level  <= win_l;
      irq_vector <= win_vec;
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !irq_valid);
  assert_level_nonzero_R8: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> irq_level != '0);
  assert_vec_grid_R7: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> (irq_vector[4:0] == 5'd0 && irq_vector >= VEC_W'(VEC_BASE)));
  assert_valid_cause_R9: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> $past(|(irq_req & src_en)));
endmodule

// File: rtl/prio_field_intc.sv
module prio_field_intc
  import prio_intc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [NUM_SRC-1:0]   irq_req,
  output logic                 irq_valid,
  output logic [FIELD_W-1:0]   irq_level,
  output logic [VEC_W-1:0]     irq_vector
);
  logic [NUM_FIELDS*FIELD_W-1:0] fields;
  logic [DATA_W-1:0]             mask;
  logic [NUM_SRC-1:0]            src_en;
  logic [NUM_SRC*FIELD_W-1:0]    src_lvl;

  prio_intc_regs u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fields(fields), .mask(mask)
  );

  prio_intc_enable u_enable (
    .fields(fields), .mask(mask), .src_en(src_en), .src_lvl(src_lvl)
  );

  prio_intc_arbiter u_arb (
    .clk(clk), .rst(rst), .irq_req(irq_req), .src_en(src_en), .src_lvl(src_lvl),
    .irq_valid(irq_valid), .irq_level(irq_level), .irq_vector(irq_vector)
  );
endmodule

// File: tb/prio_field_intc_bench.sv
module prio_field_intc_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [11:0] irq_req = '0;
  logic        irq_valid;
  logic [3:0]  irq_level;
  logic [11:0] irq_vector;

  int n_chk = 0, n_bad = 0;
  logic [15:0] m_a = '0, m_b = '0;
  logic [31:0] m_w = '0, m_m = '0;

  always #2.5 clk = ~clk;

  prio_field_intc u_prio_field_intc (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req),
    .irq_valid(irq_valid), .irq_level(irq_level), .irq_vector(irq_vector)
  );

  function automatic logic [3:0] lvl_of(int s);
    case (s)
      0: return m_a[15:12];
      1: return m_a[11:8];
      2, 3: return m_a[7:4];
      4, 5, 6, 7: return m_a[3:0];
      8: return m_b[15:12];
      9: return m_b[11:8];
      10: return m_b[7:4];
      default: return m_w[31:28];
    endcase
  endfunction

  function automatic logic en_of(int s);
    if (s == 10) return (lvl_of(s) != 0) && m_m[31];
    if (s == 11) return (lvl_of(s) != 0) && m_m[30];
    return lvl_of(s) != 0;
  endfunction

  function automatic logic [16:0] expect_out(logic [11:0] req);
    logic [3:0] bl = 0;
    logic [11:0] bv = 0;
    for (int s = 0; s < 12; s++)
      if (req[s] && en_of(s) && lvl_of(s) > bl) begin
        bl = lvl_of(s);
        bv = 12'(12'h400 + s * 32);
      end
    return {bl != 0, bl, bv};
  endfunction

  function automatic logic [31:0] expect_rd(logic [4:0] a);
    case (a)
      5'h00: return {16'h0, m_a};
      5'h04: return {16'h0, m_b};
      5'h08: return m_w;
      5'h0C, 5'h10: return m_m;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [4:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
    case (a)
      5'h00: m_a = d[15:0];
      5'h04: m_b = d[15:0];
      5'h08: m_w = d;
      5'h0C: m_m = m_m | d;
      5'h10: m_m = m_m & ~d;
      default: ;
    endcase
  endtask

  task automatic check_out(string tag);
    @(posedge clk); @(negedge clk);
    check(tag, {15'h0, irq_valid, irq_level, irq_vector}, {15'h0, expect_out(irq_req)});
  endtask

  task automatic check_rd(string tag, logic [4:0] a);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
    check(tag, bus_rdata, expect_rd(a));
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [4:0] ra;
    logic [16:0] hold;
    void'($urandom(32'h5EED1));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    irq_req = 12'hFFF;
    check_out("R1 idle after reset");
    check_rd("R1 reg A zero", 5'h00);
    check_rd("R1 wide zero", 5'h08);
    check_rd("R1 mask zero", 5'h0C);

    // R2: single field positions
    bus_write(5'h00, 32'hABCD5000); check_out("R2 src0 field");
    check_rd("R2 A readback 16b", 5'h00);
    bus_write(5'h00, 32'h0600); check_out("R2 src1 field");
    bus_write(5'h00, 32'h0); bus_write(5'h04, 32'h3400); check_out("R2 src9 over src8");
    bus_write(5'h04, 32'h000F); check_out("R2 reserved B nibble");
    bus_write(5'h04, 32'h0);

    // R5: groups, R8 tie
    bus_write(5'h00, 32'h0070);
    irq_req = 12'b0000_0000_1000; check_out("R5 timer group member 3");
    irq_req = 12'b0000_0000_1100; check_out("R8 tie lowest index");
    bus_write(5'h00, 32'h000A);
    irq_req = 12'b0000_1000_0000; check_out("R5 serial group member 7 R7");
    irq_req = 12'b0000_0011_0000; check_out("R5 serial group member 4");
    bus_write(5'h00, 32'h200A); irq_req = 12'b0000_0001_0001;
    check_out("R8 higher level wins");

    // R6/R4: doubly gated sources
    bus_write(5'h00, 32'h0); bus_write(5'h04, 32'h0090);
    irq_req = 12'hC00; check_out("R6 field only not enabled");
    bus_write(5'h0C, 32'h8000_0001); check_out("R6 src10 enabled");
    bus_write(5'h0C, 32'h4000_0000); check_rd("R4 set merges", 5'h10);
    bus_write(5'h10, 32'h8000_0000); check_out("R4 clear disables src10");
    check_rd("R4 clear merges", 5'h0C);
    bus_write(5'h08, 32'h0FFF_FFFF); check_out("R3 reserved wide fields");
    check_rd("R3 wide readback", 5'h08);
    bus_write(5'h08, 32'hCFFF_FFFF); check_out("R6 src11 both controls");

    // R10 unmapped
    hold = expect_out(irq_req);
    bus_write(5'h14, 32'hFFFF_FFFF); check_out("R10 unmapped write");
    bus_write(5'h1C, 32'h0); check_rd("R10 unmapped read", 5'h14);
    check_rd("R10 wide kept", 5'h08);

    // R11 same-value rewrite
    bus_addr = 5'h08; bus_wdata = m_w; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk); bus_wr = 1'b0;
    check("R11 rewrite cycle1", {15'h0, irq_valid, irq_level, irq_vector}, {15'h0, hold});
    check_out("R11 rewrite cycle2");

    // R9 one-cycle latency on request
    irq_req = 12'h0; @(posedge clk); @(negedge clk);
    check("R9 request drop latency", {31'h0, irq_valid}, 32'h0);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int pick = $urandom_range(0, 6);
      logic [31:0] d = $urandom;
      case (pick)
        0: ra = 5'h00; 1: ra = 5'h04; 2: ra = 5'h08;
        3: ra = 5'h0C; 4: ra = 5'h10;
        5: ra = 5'($urandom_range(0, 31));
        default: ra = 5'h00;
      endcase
      if (pick == 6) d = {m_a, m_a};
      if (($urandom & 3) == 0) d = d & 32'h1111_1111;
      irq_req = 12'($urandom);
      bus_write(ra, d);
      check_out("R8 random arbitration");
      if ((it % 4) == 0) check_rd("R9 random readback", 5'($urandom_range(0, 31)));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule